// File: doc/BRIEF.md
# Exclusive Two-Level Cache Controller

This block is a small cache controller with two levels that never hold the same block. The first level (L1) is direct-mapped. The second level (L2) is a fully associative store that takes only the lines L1 gives up. Blocks brought in from memory go straight into L1. When L1 replaces a line, that line moves into L2. An L2 hit moves the block back up into L1, and the L1 line it displaces takes the freed L2 slot, so the two levels trade lines. Since no block is held twice, the number of distinct blocks the controller can hold is the L1 line count plus the L2 entry count.

A processor makes one request at a time over a valid/ready port. Each request is a read or write of one block-sized word. The response arrives a fixed number of cycles after acceptance, and that number depends on where the block was found: L1, L2 or memory. Memory is reached through a read port that returns data in the same cycle and through a write port used only for dirty blocks leaving L2. The fixed memory latency is counted inside the controller. Writes allocate on a miss, and a block's dirty state moves with it between the levels.

Top module: `xcache_ctl`

## Requirements
- R1: A request that hits in L1 is answered with resp_valid high in the cycle right after the accepting clock edge. A read returns the stored word; a write returns the word written.
- R2: A request that hits in L2 is answered L2_LAT cycles after acceptance (default 12). Acceptance is counted as cycle 0.
- R3: A request that misses in both levels is answered MEM_LAT cycles after acceptance (default 75). It makes exactly one memory read, with mem_rd_en high for one cycle at the block address.
- R4: A block fetched from memory is placed in L1 only. A repeat access to it hits in L1, and no block is ever found in both levels at once.
- R5: A valid line displaced from L1 by a miss moves into L2. The next access to it is answered with L2 latency and makes no memory read.
- R6: On an L2 hit the promoted block leaves L2, and the L1 line it displaces moves into L2. A later access to the promoted block hits L1; a later access to the displaced block hits L2.
- R7: Any set of (number of L1 lines + L2_ENTRIES) distinct blocks that fills both levels stays fully resident. Accessing all of them again makes no memory read.
- R8: When L2 is full and takes in an L1 line, it drops the entry that entered L2 earliest. An access to the dropped block then needs a memory read.
- R9: A block dropped from L2 is written to memory (mem_wr_en for one cycle, with its address and latest data) only if it is dirty. Clean blocks are never written.
- R10: A write marks the block dirty. Later reads of that block return the written word, whichever level holds it.
- R11: After reset, req_ready is 1 and resp_valid is 0. req_ready stays low from the acceptance of an L2 or memory request until its response cycle. Requests presented while req_ready is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; empties both levels |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller free to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Block address |
| req_wdata | input | DW | Write data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | DW | Read data, or the written word for a write |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Memory read data, valid in the same cycle |
| mem_wr_en | output | 1 | Write-back strobe |
| mem_wr_addr | output | AW | Write-back address |
| mem_wr_data | output | DW | Write-back data |

## Verification
The bench uses the defaults: a 4-line L1, a 4-entry L2, 8-bit block addresses and latencies of 12 and 75. With only eight resident blocks, a stream over 32 addresses quickly reaches every case, including L1 conflicts, swaps, a full L2, FIFO drops and dirty write-backs. A bench model of the hierarchy predicts the latency, data and memory traffic of every request. Directed sequences pin down the swap, the full-capacity residency, the earliest-inserted drop, and writes presented while the port is stalled.

// File: rtl/xcache_pkg.sv
package xcache_pkg;

  typedef enum logic {SRC_L2 = 1'b0, SRC_MEM = 1'b1} fill_src_e;

  // counter preload so that the response lands in cycle `lat` after acceptance
  function automatic int wait_preload(input int lat);
    return lat - 2;
  endfunction

endpackage

// File: rtl/xc_l1_array.sv
module xc_l1_array #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_dirty,
  output logic          hit,
  output logic [DW-1:0] rd_data,
  output logic          vic_valid,
  output logic [AW-1:0] vic_addr,
  output logic [DW-1:0] vic_data,
  output logic          vic_dirty
);
  localparam int S  = 1 << IW;
  localparam int TW = AW - IW;

  logic          vld [S];
  logic [TW-1:0] tag [S];
  logic [DW-1:0] dat [S];
  logic          dty [S];

  logic [IW-1:0] idx;
  logic [TW-1:0] tg;

  assign idx       = lk_addr[IW-1:0];
  assign tg        = lk_addr[AW-1:IW];
  assign hit       = vld[idx] && (tag[idx] == tg);
  assign rd_data   = dat[idx];
  assign vic_valid = vld[idx];
  assign vic_addr  = {tag[idx], idx};
  assign vic_data  = dat[idx];
  assign vic_dirty = dty[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < S; i++) vld[i] <= 1'b0;
    end else if (wr_en) begin
      vld[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag[idx] <= tg;
      dat[idx] <= wr_data;
      dty[idx] <= wr_dirty;
    end
  end

endmodule

// File: rtl/xc_victim_fifo.sv
module xc_victim_fifo #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int N  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_addr,
  input  logic          take,
  input  logic          put,
  input  logic [AW-1:0] put_addr,
  input  logic [DW-1:0] put_data,
  input  logic          put_dirty,
  output logic          hit,
  output logic [DW-1:0] hit_data,
  output logic          hit_dirty,
  output logic          ev_en,
  output logic          ev_dirty,
  output logic [AW-1:0] ev_addr,
  output logic [DW-1:0] ev_data
);
  localparam int CNTW = $clog2(N + 1);

  // entries [0, cnt) are valid; entry 0 entered earliest
  logic [AW-1:0]   a  [N];
  logic [DW-1:0]   d  [N];
  logic            dy [N];
  logic [CNTW-1:0] cnt;

  logic [AW-1:0]   n_a  [N];
  logic [DW-1:0]   n_d  [N];
  logic            n_dy [N];
  logic [CNTW-1:0] n_cnt;

  logic [N-1:0]    match;
  logic [CNTW-1:0] hw;

  generate
    for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match[g] = (CNTW'(g) < cnt) && (a[g] == lk_addr);
    end
  endgenerate

  always_comb begin
    hw = '0;
    for (int i = N - 1; i >= 0; i--) if (match[i]) hw = CNTW'(i);
  end

  assign hit       = |match;
  assign hit_data  = d[hw];
  assign hit_dirty = dy[hw];
  assign ev_en     = put && !take && (cnt == CNTW'(N));
  assign ev_dirty  = dy[0];
  assign ev_addr   = a[0];
  assign ev_data   = d[0];

  always_comb begin
    n_cnt = cnt;
    for (int i = 0; i < N; i++) begin
      n_a[i] = a[i]; n_d[i] = d[i]; n_dy[i] = dy[i];
    end
    if (take) begin
      for (int i = 0; i < N - 1; i++) begin
        if (CNTW'(i) >= hw) begin
          n_a[i] = a[i+1]; n_d[i] = d[i+1]; n_dy[i] = dy[i+1];
        end
      end
      n_cnt = n_cnt - 1'b1;
    end
    if (put) begin
      if (n_cnt == CNTW'(N)) begin
        for (int i = 0; i < N - 1; i++) begin
          n_a[i] = n_a[i+1]; n_d[i] = n_d[i+1]; n_dy[i] = n_dy[i+1];
        end
        n_a[N-1] = put_addr; n_d[N-1] = put_data; n_dy[N-1] = put_dirty;
      end else begin
        for (int i = 0; i < N; i++) begin
          if (CNTW'(i) == n_cnt) begin
            n_a[i] = put_addr; n_d[i] = put_data; n_dy[i] = put_dirty;
          end
        end
        n_cnt = n_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < N; i++) begin
        a[i] <= '0; d[i] <= '0; dy[i] <= 1'b0;
      end
    end else begin
      cnt <= n_cnt;
      for (int i = 0; i < N; i++) begin
        a[i] <= n_a[i]; d[i] <= n_d[i]; dy[i] <= n_dy[i];
      end
    end
  end

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(N));
  p_full_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (put && !take && cnt == CNTW'(N)) |=> (cnt == CNTW'(N)));
  p_take_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !put) |=> (cnt == $past(cnt) - 1'b1));
  p_swap_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && put) |=> $stable(cnt));

endmodule

// File: rtl/xcache_ctl.sv
module xcache_ctl
  import xcache_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int L1_IW      = 2,
  parameter int L2_ENTRIES = 4,
  parameter int L2_LAT     = 12,
  parameter int MEM_LAT    = 75
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data
);
  localparam int CW = $clog2(MEM_LAT + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [AW-1:0] la;
  logic          lw;
  logic [DW-1:0] lwd;
  fill_src_e     src;

  logic [AW-1:0] lk_addr;
  logic          l1_hit, l1_vv, l1_vd;
  logic [DW-1:0] l1_rd, l1_vdat;
  logic [AW-1:0] l1_va;
  logic          l2_hit, l2_hdy, l2_ev, l2_evd;
  logic [DW-1:0] l2_hd, l2_evdat;
  logic [AW-1:0] l2_eva;

  // named events
  logic          acc, fin, ev_l1_hit, ev_promote, ev_demote, ev_wb;
  logic          l1_we, l1_wdy;
  logic [DW-1:0] l1_wd, fill_data;
  logic          fill_dirty;

  assign req_ready  = !busy;
  assign acc        = req_valid && !busy;
  assign fin        = busy && (cnt == '0);
  assign lk_addr    = busy ? la : req_addr;
  assign ev_l1_hit  = acc && l1_hit;
  assign ev_promote = fin && l2_hit;
  assign ev_demote  = fin && l1_vv;
  assign ev_wb      = l2_ev && l2_evd;

  assign fill_data  = lw ? lwd : (l2_hit ? l2_hd : mem_rd_data);
  assign fill_dirty = lw || (l2_hit && l2_hdy);
  assign l1_we      = (ev_l1_hit && req_write) || fin;
  assign l1_wd      = fin ? fill_data : req_wdata;
  assign l1_wdy     = fin ? fill_dirty : 1'b1;

  assign mem_rd_en   = fin && !l2_hit;
  assign mem_rd_addr = la;
  assign mem_wr_en   = ev_wb;
  assign mem_wr_addr = l2_eva;
  assign mem_wr_data = l2_evdat;

  xc_l1_array #(.AW(AW), .DW(DW), .IW(L1_IW)) u_l1 (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
    .wr_en(l1_we), .wr_data(l1_wd), .wr_dirty(l1_wdy),
    .hit(l1_hit), .rd_data(l1_rd),
    .vic_valid(l1_vv), .vic_addr(l1_va), .vic_data(l1_vdat), .vic_dirty(l1_vd)
  );

  xc_victim_fifo #(.AW(AW), .DW(DW), .N(L2_ENTRIES)) u_l2 (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
    .take(ev_promote), .put(ev_demote),
    .put_addr(l1_va), .put_data(l1_vdat), .put_dirty(l1_vd),
    .hit(l2_hit), .hit_data(l2_hd), .hit_dirty(l2_hdy),
    .ev_en(l2_ev), .ev_dirty(l2_evd), .ev_addr(l2_eva), .ev_data(l2_evdat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      la         <= '0;
      lw         <= 1'b0;
      lwd        <= '0;
      src        <= SRC_MEM;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (ev_l1_hit) begin
        resp_valid <= 1'b1;
        resp_rdata <= req_write ? req_wdata : l1_rd;
      end else if (acc) begin
        busy <= 1'b1;
        la   <= req_addr;
        lw   <= req_write;
        lwd  <= req_wdata;
        src  <= l2_hit ? SRC_L2 : SRC_MEM;
        cnt  <= l2_hit ? CW'(wait_preload(L2_LAT)) : CW'(wait_preload(MEM_LAT));
      end else if (fin) begin
        busy       <= 1'b0;
        resp_valid <= 1'b1;
        resp_rdata <= fill_data;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(l1_hit && l2_hit));
  p_l1_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_l1_hit |=> resp_valid);
  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !l1_hit) |=> (!req_ready && !resp_valid));
  p_wb_on_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_rd_en);
  p_src_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && src == SRC_MEM) |-> mem_rd_en);
  p_src_l2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && src == SRC_L2) |-> (!mem_rd_en && ev_promote));

endmodule

// File: tb/test_xcache_ctl.sv
module test_xcache_ctl;
  localparam int CLK_NS = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int S  = 1 << IW;
  localparam int N  = 4;
  localparam int L2L = 12;
  localparam int ML  = 75;
  localparam logic [AW-1:0] JUNK_A = 8'h51;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready, resp_valid, mem_rd_en, mem_wr_en;
  logic [AW-1:0] req_addr = '0, mem_rd_addr, mem_wr_addr;
  logic [DW-1:0] req_wdata = '0, resp_rdata, mem_rd_data, mem_wr_data;

  always #(CLK_NS/2) clk = ~clk;

  xcache_ctl #(.AW(AW), .DW(DW), .L1_IW(IW), .L2_ENTRIES(N), .L2_LAT(L2L), .MEM_LAT(ML))
  i_xcache_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  // bench memory (driven by the design) and model memory
  logic [DW-1:0] bm [256];
  logic [DW-1:0] mm [256];
  int n_rd = 0, n_wr = 0, exp_rd = 0, exp_wb = 0;
  int errors = 0, checks = 0;

  assign mem_rd_data = bm[mem_rd_addr];

  always @(posedge clk) begin
    if (mem_rd_en) n_rd++;
    if (mem_wr_en) begin
      bm[mem_wr_addr] <= mem_wr_data;
      n_wr++;
    end
  end

  // model of the hierarchy
  logic          ml_v [S];
  logic [AW-1:0] ml_a [S];
  logic [DW-1:0] ml_d [S];
  logic          ml_dy[S];
  logic [AW-1:0] q_a [N];
  logic [DW-1:0] q_d [N];
  logic          q_dy[N];
  int            qn;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < S; i++) ml_v[i] = 1'b0;
    qn = 0;
  endtask

  task automatic m_access(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] wd,
                          output int lat, output logic [DW-1:0] rd, output string lvl);
    int idx, pos;
    logic [DW-1:0] dat;
    logic dy;
    idx = int'(a) % S;
    if (ml_v[idx] && ml_a[idx] == a) begin
      lat = 1; lvl = "R1";
      if (wr) begin ml_d[idx] = wd; ml_dy[idx] = 1'b1; end
      rd = ml_d[idx];
      return;
    end
    pos = -1;
    for (int j = 0; j < qn; j++) if (q_a[j] == a) pos = j;
    if (pos >= 0) begin
      lat = L2L; lvl = "R2";
      dat = q_d[pos]; dy = q_dy[pos];
      for (int j = pos; j < qn - 1; j++) begin
        q_a[j] = q_a[j+1]; q_d[j] = q_d[j+1]; q_dy[j] = q_dy[j+1];
      end
      qn--;
    end else begin
      lat = ML; lvl = "R3";
      dat = mm[a]; dy = 1'b0;
      exp_rd++;
    end
    if (wr) begin dat = wd; dy = 1'b1; end
    if (ml_v[idx]) begin
      if (qn == N) begin
        if (q_dy[0]) begin mm[q_a[0]] = q_d[0]; exp_wb++; end
        for (int j = 0; j < N - 1; j++) begin
          q_a[j] = q_a[j+1]; q_d[j] = q_d[j+1]; q_dy[j] = q_dy[j+1];
        end
        qn--;
      end
      q_a[qn] = ml_a[idx]; q_d[qn] = ml_d[idx]; q_dy[qn] = ml_dy[idx];
      qn++;
    end
    ml_v[idx] = 1'b1; ml_a[idx] = a; ml_d[idx] = dat; ml_dy[idx] = dy;
    rd = dat;
  endtask

  task automatic do_req(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] wd,
                        input string tag_in, input bit junk);
    int exp_lat, k;
    logic [DW-1:0] exp_d;
    string lvl, tag;
    bit ready_bad;
    m_access(a, wr, wd, exp_lat, exp_d, lvl);
    tag = (tag_in == "") ? lvl : tag_in;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    k = 1; ready_bad = 1'b0;
    while (!resp_valid && k < 400) begin
      if (req_ready) ready_bad = 1'b1;
      if (junk && k < exp_lat - 1) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = JUNK_A; req_wdata = 16'hDEAD;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    check(k == exp_lat, tag, "latency", k, exp_lat);
    check(resp_rdata == exp_d, tag, "data", resp_rdata, exp_d);
    if (exp_lat > 1) check(!ready_bad, "R11", "ready low while busy", ready_bad, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int base, w0, wb0, lfsr;
    logic [AW-1:0] victim;
    for (int i = 0; i < 256; i++) begin
      bm[i] = 16'(i * 257) ^ 16'h5A5A;
      mm[i] = 16'(i * 257) ^ 16'h5A5A;
    end
    do_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
    check(resp_valid == 1'b0, "R11", "resp after reset", resp_valid, 0);
    check(mem_rd_en == 1'b0 && mem_wr_en == 1'b0, "R11", "mem idle after reset", mem_rd_en, 0);

    // fill, reuse, victim move, swap
    do_req(8'h00, 0, '0, "R3", 0);
    do_req(8'h00, 0, '0, "R4", 0);
    do_req(8'h04, 0, '0, "R3", 0);
    do_req(8'h00, 0, '0, "R5", 0);
    do_req(8'h04, 0, '0, "R6", 0);
    do_req(8'h00, 0, '0, "R6", 0);
    do_req(8'h00, 0, '0, "R6", 0);

    // dirty data follows the block
    do_req(8'h41, 1, 16'hC0DE, "R10", 0);
    do_req(8'h41, 0, '0, "R10", 0);
    do_req(8'h41, 1, 16'hBEEF, "R10", 0);
    do_req(8'h45, 0, '0, "R5", 0);
    do_req(8'h41, 0, '0, "R10", 0);

    // full capacity residency
    do_reset();
    for (int i = 0; i < 8; i++) do_req(AW'(8'h20 + i), (i < 4), 16'(16'h1100 + i), "", 0);
    base = n_rd;
    for (int i = 0; i < 8; i++) do_req(AW'(8'h20 + i), 0, '0, "", 0);
    @(negedge clk);
    check(n_rd == base, "R7", "memory reads while resident", n_rd - base, 0);

    // earliest-inserted drop with write-back
    victim = q_a[0];
    w0 = n_wr; wb0 = exp_wb;
    do_req(8'h30, 0, '0, "R8", 0);
    @(negedge clk);
    check((n_wr - w0) == (exp_wb - wb0), "R9", "write-backs on drop", n_wr - w0, exp_wb - wb0);
    do_req(victim, 0, '0, "R8", 0);

    // stalled requests ignored
    do_req(8'h50, 0, '0, "R11", 1);
    do_req(8'h54, 0, '0, "R11", 1);
    do_req(JUNK_A, 0, '0, "R11", 0);

    // sweep over 32 blocks
    lfsr = 16'hACE1;
    for (int n = 0; n < 500; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]} & 16'hFFFF;
      do_req(AW'(lfsr[4:0]), (lfsr[7:6] == 2'b00), 16'(lfsr ^ n), "", (n % 5) == 0);
    end

    @(negedge clk);
    check(n_rd == exp_rd, "R3", "total memory reads", n_rd, exp_rd);
    check(n_wr == exp_wb, "R9", "total write-backs", n_wr, exp_wb);
    base = 0;
    for (int i = 0; i < 256; i++) if (bm[i] != mm[i]) base++;
    check(base == 0, "R9", "memory image mismatches", base, 0);
    summary();
    $finish;
  end

endmodule